// File: doc/BRIEF.md
# Variable-Length Bitstream Reader

This block pulls bit fields of any length from 1 to 16 bits out of a byte-addressed memory. Software loads a starting byte address through three byte-wide writes. It then reads a 16-bit window that begins at the current bit position. The window is built from the three bytes at the pointer, which are fetched through a byte-wide request/valid memory port.

The pointer is a byte address plus a 3-bit bit offset. A step register holds the field length and the advance mode. In fixed mode the pointer moves forward as soon as the step register is written. In auto mode it moves forward each time the upper window byte is read, so a decoder can consume fields with one read per field.

Every pointer change starts a new three-byte fetch. A ready flag tells software when the window is valid again.

Top module: `bitstream_reader`

## Requirements
- R1: After reset the pointer is byte address 0 with bit offset 0, `win_ready` is low, and `mem_req` is high with `mem_addr` = 0. Once the fetch completes, the window shows the memory at address 0.
- R2: Select 0 writes address bits 7:0, select 1 writes bits 15:8 and select 2 writes the top byte (bits 23:16). Only the top-byte write clears the bit offset to 0; the other two leave the offset unchanged.
- R3: The window is {m[a+2], m[a+1], m[a]} shifted right by the bit offset, with m[a] in the least significant byte. Select 4 reads window bits 7:0 and select 5 reads window bits 15:8.
- R4: Select 3 writes the step register: bit 7 = 1 selects auto mode, and bits 3:0 give the length, where 0 means 16.
- R5: Writing select 3 with bit 7 = 0 advances the pointer at once by the newly written length.
- R6: In auto mode, writing select 3 does not move the pointer. A read of select 5 returns the window as it stands and then advances the pointer by the stored length.
- R7: An advance forms s = offset + length. It adds s[4:3] to the byte address and keeps s[2:0] as the new offset.
- R8: A read of select 4 never moves the pointer, in either mode.
- R9: A fetch requests a, a+1 and a+2 in that order. Each request holds `mem_req` and `mem_addr` steady until `mem_valid`. `win_ready` rises only after the third byte arrives. Any pointer update restarts the fetch from the first byte, so `win_ready` is low in the next cycle.
- R10: All address arithmetic, both for the fetch and for the advance, wraps modulo 2^24.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_wr | input | 1 | Register write strobe |
| acc_rd | input | 1 | Register read strobe (used for auto advance) |
| acc_sel | input | 3 | Register select |
| acc_wdata | input | 8 | Write data |
| acc_rdata | output | 8 | Read data for the selected window byte |
| win_ready | output | 1 | Window holds all three fetched bytes for the current pointer |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_valid | input | 1 | Memory read data valid |
| mem_rdata | input | 8 | Memory read data |

## Verification
The bench covers both advance modes, each run at three lengths:
- a small length, which shows the offset growing inside a byte;
- length 0 (meaning 16), which shows a skip of two whole bytes;
- a length near 15, which shows carries out of a nonzero offset.

Start addresses just below 2^24 show whether the fetch and the advance wrap. Checking the high byte in auto mode separates a design that advances before returning data from one that advances after.

Further directed cases cover three more orderings:
- rewriting a low address byte after an advance, which should keep the offset;
- a rewrite in the middle of a fetch, which tells a restart from a completion with stale data;
- a clean fetch, whose request order is logged.

// File: rtl/bsr_pkg.sv
package bsr_pkg;
    localparam int OFF_W     = 3;
    localparam int LEN_W     = 5;
    localparam int WIN_BYTES = 3;
    localparam int WIN_W     = 16;

    typedef enum logic [2:0] {
        SEL_ADR_LO  = 3'd0,
        SEL_ADR_MID = 3'd1,
        SEL_ADR_HI  = 3'd2,
        SEL_STEP    = 3'd3,
        SEL_WIN_LO  = 3'd4,
        SEL_WIN_HI  = 3'd5
    } reg_sel_e;

    typedef struct packed {
        logic             auto_mode;
        logic [LEN_W-1:0] len;
    } step_cfg_t;

    typedef struct packed {
        logic [1:0]       byte_inc;
        logic [OFF_W-1:0] off;
    } step_res_t;

    function automatic step_cfg_t decode_step(input logic [7:0] d);
        step_cfg_t c;
        c.auto_mode = d[7];
        c.len       = (d[3:0] == 4'd0) ? LEN_W'(16) : {1'b0, d[3:0]};
        return c;
    endfunction

    function automatic step_res_t step_calc(input logic [OFF_W-1:0] off,
                                            input logic [LEN_W-1:0] len);
        logic [LEN_W-1:0] s;
        step_res_t r;
        s          = {2'b00, off} + len;
        r.byte_inc = s[4:3];
        r.off      = s[2:0];
        return r;
    endfunction

    function automatic logic [WIN_W-1:0] window_of(input logic [WIN_BYTES*8-1:0] b,
                                                  input logic [OFF_W-1:0] off);
        logic [WIN_BYTES*8-1:0] sh;
        sh = b >> off;
        return sh[WIN_W-1:0];
    endfunction
endpackage

// File: rtl/bsr_ptr.sv
module bsr_ptr
    import bsr_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr,
    input  logic                rd,
    input  logic [2:0]          sel,
    input  logic [7:0]          wdata,
    output logic [ADDR_W-1:0]   base,
    output logic [OFF_W-1:0]    off,
    output logic                upd
);
    step_cfg_t        cfg, new_cfg;
    logic             step_now;
    logic [LEN_W-1:0] use_len;
    step_res_t        res;
    logic             adr_wr;

    always_comb begin
        new_cfg  = decode_step(wdata);
        step_now = 1'b0;
        use_len  = cfg.len;
        if (wr && sel == SEL_STEP && !new_cfg.auto_mode) begin
            step_now = 1'b1;
            use_len  = new_cfg.len;
        end else if (!wr && rd && sel == SEL_WIN_HI && cfg.auto_mode) begin
            step_now = 1'b1;
        end
        res    = step_calc(off, use_len);
        adr_wr = wr && (sel == SEL_ADR_LO || sel == SEL_ADR_MID || sel == SEL_ADR_HI);
        upd    = adr_wr || step_now;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            base          <= '0;
            off           <= '0;
            cfg.auto_mode <= 1'b0;
            cfg.len       <= LEN_W'(16);
        end else begin
            if (wr) begin
                case (sel)
                    SEL_ADR_LO:  base[7:0]  <= wdata;
                    SEL_ADR_MID: base[15:8] <= wdata;
                    SEL_ADR_HI: begin
                        base[ADDR_W-1:16] <= wdata[ADDR_W-17:0];
                        off               <= '0;
                    end
                    SEL_STEP:    cfg <= new_cfg;
                    default: ;
                endcase
            end
            if (step_now) begin
                base <= base + ADDR_W'(res.byte_inc);
                off  <= res.off;
            end
        end
    end

    // R2
    top_clears_off_chk: assert property (@(posedge clk) disable iff (rst)
        (wr && sel == SEL_ADR_HI) |=> (off == '0));

    // R8
    lo_read_keeps_ptr_chk: assert property (@(posedge clk) disable iff (rst)
        (rd && !wr && sel == SEL_WIN_LO) |=> ($stable(base) && $stable(off)));

    // R7
    adv_bounded_chk: assert property (@(posedge clk) disable iff (rst)
        step_now |=> (ADDR_W'(base - $past(base)) <= ADDR_W'(2)));
endmodule

// File: rtl/bsr_fetch.sv
module bsr_fetch
    import bsr_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     restart,
    input  logic [ADDR_W-1:0]        base,
    output logic                     mem_req,
    output logic [ADDR_W-1:0]        mem_addr,
    input  logic                     mem_valid,
    input  logic [7:0]               mem_rdata,
    output logic [WIN_BYTES*8-1:0]   win_bytes,
    output logic                     ready
);
    localparam int IDX_W = $clog2(WIN_BYTES);
    localparam int LAST  = WIN_BYTES - 1;

    logic             busy;
    logic [IDX_W-1:0] idx;
    logic             take;

    assign mem_req  = busy;
    assign mem_addr = base + ADDR_W'(idx);
    assign ready    = !busy;
    assign take     = busy && mem_valid && !restart;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            busy <= 1'b1;
            idx  <= '0;
        end else if (take) begin
            if (idx == IDX_W'(LAST)) busy <= 1'b0;
            else                     idx  <= idx + 1'b1;
        end
    end

    for (genvar g = 0; g < WIN_BYTES; g++) begin : g_store
        logic [7:0] slot;
        always_ff @(posedge clk) begin
            if (rst)                             slot <= '0;
            else if (take && idx == IDX_W'(g))   slot <= mem_rdata;
        end
        assign win_bytes[g*8 +: 8] = slot;
    end

    // R9
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_valid && !restart) |=> (mem_req && $stable(mem_addr)));

    // R9
    rise_after_valid_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ready) |-> $past(mem_valid));

    // R9
    restart_drop_chk: assert property (@(posedge clk) disable iff (rst)
        restart |=> !ready);
endmodule

// File: rtl/bitstream_reader.sv
module bitstream_reader
    import bsr_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_wr,
    input  logic              acc_rd,
    input  logic [2:0]        acc_sel,
    input  logic [7:0]        acc_wdata,
    output logic [7:0]        acc_rdata,
    output logic              win_ready,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_valid,
    input  logic [7:0]        mem_rdata
);
    logic [ADDR_W-1:0]      base;
    logic [OFF_W-1:0]       off;
    logic                   upd;
    logic [WIN_BYTES*8-1:0] win_bytes;
    logic [WIN_W-1:0]       window;

    bsr_ptr #(.ADDR_W(ADDR_W)) u_ptr (
        .clk(clk), .rst(rst), .wr(acc_wr), .rd(acc_rd), .sel(acc_sel),
        .wdata(acc_wdata), .base(base), .off(off), .upd(upd)
    );

    bsr_fetch #(.ADDR_W(ADDR_W)) u_fetch (
        .clk(clk), .rst(rst), .restart(upd), .base(base),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_valid(mem_valid),
        .mem_rdata(mem_rdata), .win_bytes(win_bytes), .ready(win_ready)
    );

    assign window = window_of(win_bytes, off);

    always_comb begin
        case (acc_sel)
            SEL_WIN_LO: acc_rdata = window[7:0];
            SEL_WIN_HI: acc_rdata = window[15:8];
            default:    acc_rdata = 8'h00;
        endcase
    end

    // R1
    reset_fetch_chk: assert property (@(posedge clk)
        $past(rst) |-> (mem_req && !win_ready));
endmodule

// File: tb/test_bitstream_reader.sv
module test_bitstream_reader;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        acc_wr = 1'b0, acc_rd = 1'b0;
    logic [2:0]  acc_sel = 3'd0;
    logic [7:0]  acc_wdata = 8'd0;
    logic [7:0]  acc_rdata;
    logic        win_ready, mem_req, mem_valid;
    logic [23:0] mem_addr;
    logic [7:0]  mem_rdata;

    int checks = 0, fails = 0, cycles = 0;

    always #2.5 clk = ~clk;

    bitstream_reader #(.ADDR_W(24)) i_bitstream_reader (
        .clk(clk), .rst(rst), .acc_wr(acc_wr), .acc_rd(acc_rd), .acc_sel(acc_sel),
        .acc_wdata(acc_wdata), .acc_rdata(acc_rdata), .win_ready(win_ready),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_valid(mem_valid),
        .mem_rdata(mem_rdata)
    );

    function automatic logic [7:0] byte_at(input logic [23:0] a);
        logic [7:0] p;
        p = a[7:0] * 8'd37;
        return p ^ a[15:8] ^ {a[20:16], a[23:21]} ^ 8'h5A;
    endfunction

    // memory model: answers one cycle after a stable request
    logic [23:0] held_addr = '0;
    logic        held_req  = 1'b0;
    always @(posedge clk) begin
        held_addr <= mem_addr;
        held_req  <= mem_req;
    end
    assign mem_valid = mem_req && held_req && (held_addr == mem_addr);
    assign mem_rdata = byte_at(mem_addr);

    // log of accepted fetch addresses
    logic [23:0] acc_log [4];
    int          log_n = 0;
    always @(posedge clk) begin
        if (mem_req && mem_valid && log_n < 4) begin
            acc_log[log_n] <= mem_addr;
            log_n <= log_n + 1;
        end
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == 50000) begin
            checks++; fails++;
            $display("FAIL watchdog: run did not finish, actual %0d cycles expected fewer", cycles);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    logic [23:0] m_addr;
    int          m_off;

    function automatic logic [15:0] exp_win(input logic [23:0] a, input int o);
        logic [23:0] w;
        w = {byte_at(a + 24'd2), byte_at(a + 24'd1), byte_at(a)};
        w = w >> o;
        return w[15:0];
    endfunction

    task automatic m_adv(input int len);
        int s;
        s = m_off + len;
        m_addr = m_addr + 24'(s / 8);
        m_off  = s % 8;
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [2:0] sel, input logic [7:0] d);
        @(negedge clk);
        acc_wr = 1'b1; acc_sel = sel; acc_wdata = d;
        @(negedge clk);
        acc_wr = 1'b0;
    endtask

    task automatic peek(input logic [2:0] sel, output logic [7:0] v);
        @(negedge clk);
        acc_sel = sel;
        #1 v = acc_rdata;
    endtask

    task automatic rd_reg(input logic [2:0] sel, output logic [7:0] v);
        @(negedge clk);
        acc_rd = 1'b1; acc_sel = sel;
        #1 v = acc_rdata;
        @(negedge clk);
        acc_rd = 1'b0;
    endtask

    task automatic wait_ready();
        int n = 0;
        while (!win_ready && n < 200) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic set_addr(input logic [23:0] a);
        wr_reg(3'd0, a[7:0]);
        wr_reg(3'd1, a[15:8]);
        wr_reg(3'd2, a[23:16]);
        m_addr = a; m_off = 0;
    endtask

    task automatic check_win(input string req);
        logic [7:0] lo, hi;
        logic [15:0] e;
        wait_ready();
        e = exp_win(m_addr, m_off);
        peek(3'd4, lo);
        peek(3'd5, hi);
        check(req, {16'd0, hi, lo}, {16'd0, e});
    endtask

    // {start address, step register value}
    localparam logic [31:0] VEC [6] = '{
        {24'h000100, 8'h05},
        {24'h00ABCD, 8'h00},
        {24'hFFFFFE, 8'h0C},
        {24'h123456, 8'h83},
        {24'hFFFFFF, 8'h80},
        {24'h7F0010, 8'h8F}
    };

    initial begin
        logic [7:0] v, v2;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state, first negedge after release
        #1;
        check("R1 ready low", {31'd0, win_ready}, 32'd0);
        check("R1 req high at 0", {7'd0, mem_req, mem_addr}, {7'd0, 1'b1, 24'd0});
        m_addr = 24'd0; m_off = 0;
        check_win("R1 window at address 0");

        // table walk: R3, R4, R5, R6, R7, R10
        foreach (VEC[i]) begin
            logic [23:0] a;
            logic [7:0]  c;
            int len;
            a = VEC[i][31:8];
            c = VEC[i][7:0];
            len = (c[3:0] == 4'd0) ? 16 : int'(c[3:0]);
            set_addr(a);
            check_win("R3 window at start");
            if (!c[7]) begin
                wr_reg(3'd3, c);
                m_adv(len);
                check_win("R5 fixed advance");
                wr_reg(3'd3, c);
                m_adv(len);
                check_win("R7 second fixed advance");
            end else begin
                wr_reg(3'd3, c);
                check("R6 auto step write keeps ready", {31'd0, win_ready}, 32'd1);
                check_win("R6 auto step write no move");
                rd_reg(3'd5, v);
                check("R6 high read returns current", {24'd0, v}, {24'd0, exp_win(m_addr, m_off)} >> 8);
                m_adv(len);
                check_win("R7 auto advance");
                wait_ready();
                rd_reg(3'd5, v);
                m_adv(len);
                check_win("R10 second auto advance");
            end
        end

        // R8: low read in auto mode never moves pointer
        set_addr(24'h000300);
        wr_reg(3'd3, 8'h87);
        wait_ready();
        rd_reg(3'd4, v);
        rd_reg(3'd4, v2);
        check("R8 ready stays high", {31'd0, win_ready}, 32'd1);
        check("R8 low read stable", {24'd0, v2}, {24'd0, exp_win(m_addr, m_off)} & 32'hFF);
        check_win("R8 window unchanged");

        // R2: low write keeps offset, top write clears it
        set_addr(24'h000200);
        wr_reg(3'd3, 8'h03);
        m_adv(3);
        check_win("R2 after advance");
        wr_reg(3'd0, 8'h40);
        m_addr = 24'h000240;
        check_win("R2 low write keeps offset");
        wr_reg(3'd2, 8'h00);
        m_off = 0;
        check_win("R2 top write clears offset");

        // R9: fetch order and ready drop
        wait_ready();
        wr_reg(3'd0, 8'h77);
        m_addr = 24'h000277;
        log_n = 0;
        check("R9 ready low after update", {31'd0, win_ready}, 32'd0);
        wait_ready();
        check("R9 order byte 0", {8'd0, acc_log[0]}, {8'd0, m_addr});
        check("R9 order byte 1", {8'd0, acc_log[1]}, {8'd0, m_addr + 24'd1});
        check("R9 order byte 2", {8'd0, acc_log[2]}, {8'd0, m_addr + 24'd2});

        // R9: rewrite during a fetch restarts it
        wr_reg(3'd0, 8'h10);
        wr_reg(3'd0, 8'h90);
        m_addr = 24'h000290;
        check_win("R9 restart mid fetch");

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule